// File: doc/BRIEF.md
# Stereo Digital Volume with Soft Mute

This block scales a stream of 24-bit signed stereo samples by a per-channel attenuation code. Each code maps linearly to a gain. Code 0 passes the sample at full scale, and each step up removes 1/256 of full scale. A common-control input makes the left code govern both channels, so that one register write moves the stereo volume together.

A soft-mute request moves the applied gain smoothly instead of cutting it. A ramp counter runs from full (1024) down to zero, one step per accepted sample. The multiplier seen by a sample is the product of the code gain and the ramp fraction. Removing the request reverses the ramp at once from wherever it stands, so the gain climbs back over exactly as many samples as it spent falling. A status output reports when the ramp has reached silence.

Samples enter with a valid strobe. They leave two clock cycles later with their own valid strobe, rounded and clamped to 24 bits.

Top module: `stereo_softmute_vol`

## Requirements
- R1: After reset `valid_o` and `mute_done_o` are low and the ramp stands at full, so a sample sent with code 0 and no mute returns unchanged.
- R2: Each cycle with `valid_i` high produces exactly one cycle of `valid_o` two clock cycles later; `valid_o` is otherwise low.
- R3: Each output equals floor((x·(256−code)·ramp + 2^17) / 2^18) clamped to the signed 24-bit range, where x is the input sample, code is the channel's 8-bit code and ramp (0..1024) is the ramp value before that sample's update.
- R4: With `common_i` high, both channels use `left_code_i` and `right_code_i` has no effect on either output.
- R5: With `common_i` low, the left channel uses `left_code_i` and the right channel uses `right_code_i`.
- R6: While `mute_i` is high, each accepted sample lowers the ramp by one until it reaches 0; from 1024 the 1025th muted sample and all later ones output 0.
- R7: `mute_done_o` rises at the clock edge where the ramp reaches 0, and falls at the edge of the first sample accepted with `mute_i` low.
- R8: When `mute_i` falls after k muted samples, the ramp rises by one per accepted sample, and after k such samples the gain is back at the code's gain.
- R9: The ramp moves only on cycles with `valid_i` high; idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| left_i | input | 24 | Left input sample, signed |
| right_i | input | 24 | Right input sample, signed |
| left_code_i | input | 8 | Left attenuation code, 0 = full scale |
| right_code_i | input | 8 | Right attenuation code |
| common_i | input | 1 | Left code drives both channels |
| mute_i | input | 1 | Soft-mute request |
| valid_o | output | 1 | Output sample strobe |
| left_o | output | 24 | Left output sample, signed |
| right_o | output | 24 | Right output sample, signed |
| mute_done_o | output | 1 | Ramp has reached zero |

## Verification
The hardest state to reach is a mute release in the middle of a ramp after an irregular number of samples, while idle cycles are interleaved. Under those conditions an off-by-one in the step count or a step taken on an idle cycle shows up only as a small gain error many samples later. The stimulus interleaves random idle gaps with random-length mute bursts and releases. It then runs a full 1024-sample fall and checks the status edge on the exact sample. The bench's own ramp model tracks every step, and each output is compared against a gain computed from that model.

// File: rtl/svol_pkg.sv
package svol_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/svol_ramp.sv
module svol_ramp
  import svol_pkg::*;
#(
  parameter int RAMP_STEPS = 1024,
  parameter int R_W        = $clog2(RAMP_STEPS) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic           mute_i,
  output logic [R_W-1:0] ramp_o,
  output logic           done_o
);
  localparam logic [R_W-1:0] FULL = R_W'(RAMP_STEPS);

  logic [R_W-1:0] ramp_q;
  logic           done_q;
  ramp_dir_e      dir;

  always_comb begin
    dir = RAMP_HOLD;
    if (step_i) begin
      if (mute_i && ramp_q != '0)       dir = RAMP_DOWN;
      else if (!mute_i && ramp_q != FULL) dir = RAMP_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= FULL;
      done_q <= 1'b0;
    end else begin
      unique case (dir)
        RAMP_DOWN: begin
          ramp_q <= ramp_q - 1'b1;
          done_q <= (ramp_q == R_W'(1));
        end
        RAMP_UP: begin
          ramp_q <= ramp_q + 1'b1;
          done_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign ramp_o = ramp_q;
  assign done_o = done_q;
endmodule

// File: rtl/svol_gain.sv
module svol_gain
  import svol_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8,
  parameter int R_W    = 11,
  parameter int M_W    = CODE_W + 1 + R_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  input  logic [CODE_W-1:0]        left_code_i,
  input  logic [CODE_W-1:0]        right_code_i,
  input  logic                     common_i,
  input  logic [R_W-1:0]           ramp_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] smp_o  [NUM_CH],
  output logic [M_W-1:0]           mult_o [NUM_CH]
);
  localparam int G_W = CODE_W + 1;
  localparam logic [G_W-1:0] UNITY = G_W'(1) << CODE_W;

  logic [CODE_W-1:0]        code [NUM_CH];
  logic signed [DATA_W-1:0] smp  [NUM_CH];

  assign code[0] = left_code_i;
  assign code[1] = common_i ? left_code_i : right_code_i;
  assign smp[0]  = left_i;
  assign smp[1]  = right_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [G_W-1:0] gain;
    logic [M_W-1:0] mult;

    assign gain = UNITY - G_W'(code[ch]);
    assign mult = M_W'(gain) * M_W'(ramp_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_o[ch]  <= '0;
        mult_o[ch] <= '0;
      end else if (valid_i) begin
        smp_o[ch]  <= smp[ch];
        mult_o[ch] <= mult;
      end
    end
  end
endmodule

// File: rtl/svol_scale.sv
module svol_scale #(
  parameter int DATA_W = 24,
  parameter int M_W    = 20,
  parameter int SHIFT  = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic [M_W-1:0]           mult_i,
  output logic signed [DATA_W-1:0] smp_o
);
  localparam int PW = DATA_W + M_W + 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SHIFT - 1);

  logic signed [PW-1:0]     prod, rnd, shf;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    prod = PW'(smp_i) * PW'($signed({1'b0, mult_i}));
    rnd  = prod + HALF;
    shf  = rnd >>> SHIFT;
    if (shf > MAXV)      sat = MAXV[DATA_W-1:0];
    else if (shf < MINV) sat = MINV[DATA_W-1:0];
    else                 sat = shf[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      smp_o <= '0;
    else if (valid_i) smp_o <= sat;
  end
endmodule

// File: rtl/stereo_softmute_vol.sv
module stereo_softmute_vol
  import svol_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int CODE_W     = 8,
  parameter int RAMP_STEPS = 1024
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  input  logic [CODE_W-1:0]        left_code_i,
  input  logic [CODE_W-1:0]        right_code_i,
  input  logic                     common_i,
  input  logic                     mute_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o,
  output logic                     mute_done_o
);
  localparam int RAMP_LOG2 = $clog2(RAMP_STEPS);
  localparam int R_W       = RAMP_LOG2 + 1;
  localparam int M_W       = CODE_W + 1 + R_W;
  localparam int SHIFT     = CODE_W + RAMP_LOG2;

  logic [R_W-1:0]           ramp_q;
  logic                     s1_valid;
  logic signed [DATA_W-1:0] s1_smp  [NUM_CH];
  logic [M_W-1:0]           s1_mult [NUM_CH];
  logic signed [DATA_W-1:0] s2_smp  [NUM_CH];
  logic                     s2_valid;

  svol_ramp #(.RAMP_STEPS(RAMP_STEPS), .R_W(R_W)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (valid_i),
    .mute_i (mute_i),
    .ramp_o (ramp_q),
    .done_o (mute_done_o)
  );

  svol_gain #(.DATA_W(DATA_W), .CODE_W(CODE_W), .R_W(R_W), .M_W(M_W)) u_gain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .left_i       (left_i),
    .right_i      (right_i),
    .left_code_i  (left_code_i),
    .right_code_i (right_code_i),
    .common_i     (common_i),
    .ramp_i       (ramp_q),
    .valid_o      (s1_valid),
    .smp_o        (s1_smp),
    .mult_o       (s1_mult)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_scale
    svol_scale #(.DATA_W(DATA_W), .M_W(M_W), .SHIFT(SHIFT)) u_scale (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (s1_valid),
      .smp_i   (s1_smp[ch]),
      .mult_i  (s1_mult[ch]),
      .smp_o   (s2_smp[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s2_valid <= 1'b0;
    else         s2_valid <= s1_valid;
  end

  assign valid_o = s2_valid;
  assign left_o  = s2_smp[0];
  assign right_o = s2_smp[1];
endmodule

// File: rtl/stereo_softmute_vol_chk.sv
module stereo_softmute_vol_chk #(
  parameter int RAMP_STEPS = 1024,
  parameter int R_W        = 11
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           mute_i,
  input logic           valid_o,
  input logic           mute_done_o,
  input logic [R_W-1:0] ramp_i
);
  assert_valid_fwd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);

  assert_valid_back_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));

  assert_ramp_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_i <= R_W'(RAMP_STEPS));

  assert_ramp_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mute_i && ramp_i != '0) |=> ramp_i == $past(ramp_i) - 1'b1);

  assert_ramp_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mute_i && ramp_i != R_W'(RAMP_STEPS)) |=> ramp_i == $past(ramp_i) + 1'b1);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ramp_i));

  assert_done_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_done_o |-> ramp_i == '0);

  assert_done_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_done_o) |-> $past(valid_i && mute_i));
endmodule

bind stereo_softmute_vol stereo_softmute_vol_chk #(
  .RAMP_STEPS (RAMP_STEPS),
  .R_W        (R_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .mute_i      (mute_i),
  .valid_o     (valid_o),
  .mute_done_o (mute_done_o),
  .ramp_i      (ramp_q)
);

// File: tb/stereo_softmute_vol_bench.sv
module stereo_softmute_vol_bench;
  localparam int FULL = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic signed [23:0] left_i = '0, right_i = '0;
  logic [7:0]  left_code_i = '0, right_code_i = '0;
  logic        common_i = 1'b1, mute_i = 1'b0;
  logic        valid_o, mute_done_o;
  logic signed [23:0] left_o, right_o;

  int tests = 0, fails = 0;
  int rm = FULL;
  bit exp_done = 1'b0;
  bit finished = 1'b0;
  longint q_l[$], q_r[$];
  string  q_t[$];

  always #5 clk_i = ~clk_i;

  stereo_softmute_vol u_stereo_softmute_vol (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .left_i(left_i), .right_i(right_i),
    .left_code_i(left_code_i), .right_code_i(right_code_i), .common_i(common_i),
    .mute_i(mute_i), .valid_o(valid_o), .left_o(left_o), .right_o(right_o),
    .mute_done_o(mute_done_o)
  );

  function automatic longint exp_val(longint x, int code, int r);
    longint p, q;
    p = x * longint'(256 - code) * longint'(r);
    q = (p + (longint'(1) <<< 17)) >>> 18;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives one sample for one cycle; returns at the negedge after its edge
  task automatic send(longint xl, longint xr, int cl, int cr, bit com, bit mu, string req);
    int cr_eff;
    left_i = 24'(xl); right_i = 24'(xr);
    left_code_i = 8'(cl); right_code_i = 8'(cr);
    common_i = com; mute_i = mu; valid_i = 1'b1;
    cr_eff = com ? cl : cr;
    q_l.push_back(exp_val(xl, cl, rm));
    q_r.push_back(exp_val(xr, cr_eff, rm));
    q_t.push_back(req);
    if (mu && rm > 0) begin
      rm--;
      exp_done = (rm == 0);
    end else if (!mu && rm < FULL) begin
      rm++;
      exp_done = 1'b0;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  function automatic longint rnd_smp();
    return longint'($signed(24'($urandom)));
  endfunction

  // output monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (valid_o) begin
        if (q_l.size() == 0) begin
          check("R2 unexpected valid_o", 1, 0);
        end else begin
          string t;
          t = q_t.pop_front();
          check({t, " left"},  longint'(left_o),  q_l.pop_front());
          check({t, " right"}, longint'(right_o), q_r.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    if (!finished) $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk_i);
    check("R1 valid_o after reset", longint'(valid_o), 0);
    check("R1 mute_done_o after reset", longint'(mute_done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 full ramp at reset: code 0 passes the sample unchanged
    send(1234567, -7654321, 0, 0, 1'b0, 1'b0, "R1 unity after reset");
    idle(3);

    // R2 latency of exactly two edges
    left_i = 24'sd100; right_i = 24'sd100; valid_i = 1'b1; common_i = 1'b0;
    left_code_i = 8'd0; right_code_i = 8'd0; mute_i = 1'b0;
    q_l.push_back(100); q_r.push_back(100); q_t.push_back("R2 latency sample");
    @(negedge clk_i); valid_i = 1'b0;
    check("R2 valid_o low after one edge", longint'(valid_o), 0);
    @(negedge clk_i);
    check("R2 valid_o high after two edges", longint'(valid_o), 1);
    @(negedge clk_i);
    check("R2 valid_o single pulse", longint'(valid_o), 0);

    // R3 boundary samples and codes
    send(8388607, -8388608, 0, 0, 1'b0, 1'b0, "R3 extremes unity");
    send(8388607, -8388608, 255, 255, 1'b0, 1'b0, "R3 extremes code 255");
    send(-129, 127, 255, 128, 1'b0, 1'b0, "R3 rounding");
    idle(3);

    // R5 independent codes, back-to-back and gapped
    for (int i = 0; i < 40; i++) begin
      send(rnd_smp(), rnd_smp(), int'($urandom_range(255)), int'($urandom_range(255)),
           1'b0, 1'b0, "R5 independent codes");
      if ($urandom_range(1) == 1) idle(int'($urandom_range(3)));
    end

    // R4 common control ignores right code
    for (int i = 0; i < 40; i++) begin
      send(rnd_smp(), rnd_smp(), int'($urandom_range(255)), int'($urandom_range(255)),
           1'b1, 1'b0, "R4 common control");
    end
    idle(3);

    // R8/R9 mid-ramp reversals with idle gaps
    for (int b = 0; b < 4; b++) begin
      int k;
      k = int'($urandom_range(200, 20));
      for (int i = 0; i < k; i++) begin
        send(rnd_smp(), rnd_smp(), int'($urandom_range(64)), int'($urandom_range(64)),
             1'b0, 1'b1, "R9 mute ramp with gaps");
        if ($urandom_range(3) == 0) idle(int'($urandom_range(4, 1)));
      end
      for (int i = 0; i < k; i++) begin
        send(rnd_smp(), rnd_smp(), int'($urandom_range(64)), int'($urandom_range(64)),
             1'b0, 1'b0, "R8 release ramp");
        if ($urandom_range(3) == 0) idle(int'($urandom_range(4, 1)));
      end
      check("R8 mute_done_o low after release", longint'(mute_done_o), 0);
      // gain restored: code 0 must be unity
      send(-4000001, 3999999, 0, 0, 1'b0, 1'b0, "R8 gain restored");
    end
    idle(3);

    // R6/R7 full fall to silence
    for (int i = 0; i < FULL + 6; i++) begin
      send(rnd_smp(), rnd_smp(), 0, 0, 1'b1, 1'b1, "R6 full mute");
      if (i == FULL - 2 || i == FULL - 1 || i == FULL + 5)
        check("R7 mute_done_o during fall", longint'(mute_done_o), longint'(exp_done));
    end
    send(8388607, -8388608, 0, 0, 1'b1, 1'b1, "R6 silence at extremes");
    idle(2);
    check("R9 mute_done_o holds over idle", longint'(mute_done_o), 1);
    send(5000000, -5000000, 0, 0, 1'b1, 1'b0, "R7 first up step");
    check("R7 mute_done_o clears on first up step", longint'(mute_done_o), 0);
    for (int i = 0; i < FULL + 2; i++)
      send(rnd_smp(), rnd_smp(), 0, 0, 1'b1, 1'b0, "R8 full climb");
    idle(4);

    check("R2 all outputs delivered", longint'(q_l.size()), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule